// File: doc/BRIEF.md
# Serial Control Register Bank

This block receives configuration words over a write-only three-wire serial link (serial clock, serial data, load strobe) and holds eight control registers. Each of them drives a group of decoded control fields: power state, band choice, transmit gain, gain-source choice, reference and oscillator options, and the divider values for two frequency synthesizers. A host holds the load strobe high while idle. It pulls the strobe low, clocks in sixteen bits with the most significant bit first, and raises the strobe again. The low byte of the word selects the target register through a fixed 8-bit pattern, and the high byte is the new content.

All serial inputs are brought into the system clock domain through synchronizer stages, and the edges of the serial clock and strobe are found by oversampling. A word is accepted only when the strobe rises after exactly sixteen serial clock rising edges and the address pattern is known. The whole register byte then changes in a single system clock cycle. While the power enable input is low the port is asleep: every register holds its default value. The port accepts data again only after a wake-up delay that follows the rising edge of power enable.

Top module: `ctl_sbank`

## Requirements
- R1: After asynchronous reset, and at every rising edge of power enable, the fields read: pwr_state 0, band_a 0, gain_pin_sel 1, tx_hilin 0, ref_sel 0, frac_if_en 0, cp_cont 0, tx_gain 0, ref_prediv 1, rf_mod 79, spec_inv 1, if_frac 0, ref_mode 0, if_mod 0, if_div_hi 0, if_div_lo 0, xo_lowpwr 1, rf_frac 48, rf_div_hi 10, rf_div_lo 0.
- R2: While ser_ld is low, each rising edge of ser_clk shifts ser_dat in with the most significant bit first. The word is applied when ser_ld rises.
- R3: The low byte selects the register: 0xDA reg1, 0xDF reg2, 0xDD reg3, 0xD8 reg4, 0xD9 reg5, 0xDB reg6, 0xDC reg7, 0xDE reg8. The high byte (bits 15..8) maps as follows. reg1: 15 gain_pin_sel, 14 tx_hilin, 13 ref_sel, 12 frac_if_en, 11 unused, 10 band_a, 9..8 pwr_state. reg2: 15 cp_cont, 14..10 tx_gain, 9..8 unused. reg3: 15 ref_prediv, 14..8 rf_mod. reg4: 15 spec_inv, 14..8 if_frac. reg5: 15 ref_mode, 14..8 if_mod. reg6: 15..11 if_div_hi, 10..8 if_div_lo. reg7: 15 xo_lowpwr, 14..8 rf_frac. reg8: 15..11 rf_div_hi, 10..8 rf_div_lo.
- R4: A word whose low byte matches none of the eight patterns leaves every field unchanged.
- R5: A transfer with fewer or more than 16 serial clock rising edges between the falling and rising edges of ser_ld leaves every field unchanged.
- R6: Fields do not change while a transfer is in progress. A register's fields all change in the same clock cycle.
- R7: While pwr_en is low, all fields hold their defaults and serial transfers have no effect.
- R8: Serial clock edges in the first WAKE_CYCLES system cycles after the synchronized rise of pwr_en are ignored. A transfer that overlaps this window is therefore discarded.
- R9: Lowering and then raising pwr_en brings back the defaults, so values written earlier are lost.
- R10: Serial clock edges while ser_ld is high do not shift and do not affect the next transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial link |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_en | input | 1 | Power enable; low means sleep |
| ser_clk | input | 1 | Serial clock |
| ser_dat | input | 1 | Serial data, MSB first |
| ser_ld | input | 1 | Load strobe, idle high |
| pwr_state | output | 2 | Power state field |
| band_a | output | 1 | Band choice, 1 selects band A |
| gain_pin_sel | output | 1 | Gain source, 1 selects the parallel pins |
| tx_hilin | output | 1 | Transmit high-linearity mode |
| ref_sel | output | 1 | Reference select bit |
| frac_if_en | output | 1 | Fractional IF synthesizer enable |
| cp_cont | output | 1 | Continuous charge pump current |
| tx_gain | output | 5 | Serial transmit gain code |
| ref_prediv | output | 1 | Reference prescaler enable |
| rf_mod | output | 7 | RF synthesizer modulus field |
| spec_inv | output | 1 | Spectral inversion |
| if_frac | output | 7 | IF synthesizer fraction field |
| ref_mode | output | 1 | Reference mode bit |
| if_mod | output | 7 | IF synthesizer modulus field |
| if_div_hi | output | 5 | IF divider high field |
| if_div_lo | output | 3 | IF divider low field |
| xo_lowpwr | output | 1 | Crystal oscillator low-power mode |
| rf_frac | output | 7 | RF synthesizer fraction field |
| rf_div_hi | output | 5 | RF divider high field |
| rf_div_lo | output | 3 | RF divider low field |

## Verification
On every cycle the assertions check four things. Register contents stay unchanged unless a commit pulse occurs or the port is asleep. Sleep forces the default image, and a rise of power enable presents that image. A commit happens only one cycle after a synchronized strobe rise and never right after wake-up, and at most one register matches a committed address. Other behaviours depend on the serial history and can only be shown by the bench's scenarios: MSB-first bit order, the exact field positions for each pattern, rejection of short and long transfers and of unknown patterns, clock edges ignored while the strobe is high, and the loss of a transfer that overlaps the wake-up window.

// File: rtl/ctl_sbank_pkg.sv
`timescale 1ns/1ps
package ctl_sbank_pkg;
  localparam int WORD_W = 16;
  localparam int ADDR_W = 8;
  localparam int DATA_W = WORD_W - ADDR_W;
  localparam int N_REGS = 8;
  localparam int RAW_W  = N_REGS * DATA_W;

  // address pattern carried in the low byte, per register index
  function automatic logic [ADDR_W-1:0] reg_pat(input int idx);
    case (idx)
      0:       reg_pat = 8'hDA;
      1:       reg_pat = 8'hDF;
      2:       reg_pat = 8'hDD;
      3:       reg_pat = 8'hD8;
      4:       reg_pat = 8'hD9;
      5:       reg_pat = 8'hDB;
      6:       reg_pat = 8'hDC;
      default: reg_pat = 8'hDE;
    endcase
  endfunction

  // power-up content of each register byte
  function automatic logic [DATA_W-1:0] dflt_byte(input int idx);
    case (idx)
      0:       dflt_byte = 8'h80;  // gain source from pins
      2:       dflt_byte = 8'hCF;  // prescaler on, modulus 79
      3:       dflt_byte = 8'h80;  // spectral inversion on
      6:       dflt_byte = 8'hB0;  // xo low power, fraction 48
      7:       dflt_byte = 8'h50;  // divider 10, low field 0
      default: dflt_byte = 8'h00;
    endcase
  endfunction

  function automatic logic [RAW_W-1:0] dflt_all();
    logic [RAW_W-1:0] r;
    r = '0;
    for (int i = 0; i < N_REGS; i++) r[i*DATA_W +: DATA_W] = dflt_byte(i);
    return r;
  endfunction
endpackage

// File: rtl/ctl_sbank_sync.sv
`timescale 1ns/1ps
module ctl_sbank_sync #(
  parameter int               N_SIG   = 4,
  parameter int               STAGES  = 2,
  parameter logic [N_SIG-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SIG-1:0] d,
  output logic [N_SIG-1:0] q
);
  logic [N_SIG-1:0] stg [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      logic [N_SIG-1:0] src;
      if (s == 0) begin : g_first
        assign src = d;
      end else begin : g_next
        assign src = stg[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= RST_VAL;
        else        stg[s] <= src;
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/ctl_sbank_frame.sv
`timescale 1ns/1ps
module ctl_sbank_frame
  import ctl_sbank_pkg::*;
#(
  parameter int WAKE_CYCLES = 63
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pe_s,
  input  logic              ld_s,
  input  logic              sclk_s,
  input  logic              sdat_s,
  output logic              ready,
  output logic              commit,
  output logic [WORD_W-1:0] word
);
  localparam int CNT_W  = $clog2(WORD_W + 2);
  localparam int WAKE_W = $clog2(WAKE_CYCLES + 1);
  localparam logic [CNT_W-1:0]  CNT_FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0]  CNT_SAT  = CNT_W'(WORD_W + 1);
  localparam logic [WAKE_W-1:0] WAKE_END = WAKE_W'(WAKE_CYCLES);

  logic              sclk_q, ld_q;
  logic [WORD_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [WAKE_W-1:0] wcnt_q, wcnt_d;
  logic              commit_q, commit_d;
  logic [WORD_W-1:0] word_q;
  logic              clk_rise, ld_rise, ld_fall, shift_en;

  assign clk_rise = sclk_s & ~sclk_q;
  assign ld_rise  = ld_s & ~ld_q;
  assign ld_fall  = ~ld_s & ld_q;
  assign ready    = pe_s && (wcnt_q == WAKE_END);
  assign shift_en = ready && clk_rise && !ld_s;

  always_comb begin
    wcnt_d = wcnt_q;
    if (!pe_s)                  wcnt_d = '0;
    else if (wcnt_q != WAKE_END) wcnt_d = wcnt_q + 1'b1;

    cnt_d = cnt_q;
    if (!ready || ld_fall)                cnt_d = '0;
    else if (shift_en && cnt_q != CNT_SAT) cnt_d = cnt_q + 1'b1;

    sh_d = shift_en ? {sh_q[WORD_W-2:0], sdat_s} : sh_q;
    commit_d = ready && ld_rise && (cnt_q == CNT_FULL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q   <= 1'b0;
      ld_q     <= 1'b1;
      sh_q     <= '0;
      cnt_q    <= '0;
      wcnt_q   <= '0;
      commit_q <= 1'b0;
      word_q   <= '0;
    end else begin
      sclk_q   <= sclk_s;
      ld_q     <= ld_s;
      sh_q     <= sh_d;
      cnt_q    <= cnt_d;
      wcnt_q   <= wcnt_d;
      commit_q <= commit_d;
      if (commit_d) word_q <= sh_q;
    end
  end

  assign commit = commit_q;
  assign word   = word_q;
endmodule

// File: rtl/ctl_sbank_regs.sv
`timescale 1ns/1ps
module ctl_sbank_regs
  import ctl_sbank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pe_s,
  input  logic              commit,
  input  logic [WORD_W-1:0] word,
  output logic [RAW_W-1:0]  raw,
  output logic [N_REGS-1:0] hit
);
  genvar g;
  generate
    for (g = 0; g < N_REGS; g++) begin : g_reg
      logic [DATA_W-1:0] q_r, d_r;
      assign hit[g] = commit && (word[ADDR_W-1:0] == reg_pat(g));
      always_comb begin
        if (!pe_s)       d_r = dflt_byte(g);
        else if (hit[g]) d_r = word[WORD_W-1:ADDR_W];
        else             d_r = q_r;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_r <= dflt_byte(g);
        else        q_r <= d_r;
      end
      assign raw[g*DATA_W +: DATA_W] = q_r;
    end
  endgenerate
endmodule

// File: rtl/ctl_sbank.sv
`timescale 1ns/1ps
module ctl_sbank
  import ctl_sbank_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int WAKE_CYCLES = 63
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_en,
  input  logic       ser_clk,
  input  logic       ser_dat,
  input  logic       ser_ld,
  output logic [1:0] pwr_state,
  output logic       band_a,
  output logic       gain_pin_sel,
  output logic       tx_hilin,
  output logic       ref_sel,
  output logic       frac_if_en,
  output logic       cp_cont,
  output logic [4:0] tx_gain,
  output logic       ref_prediv,
  output logic [6:0] rf_mod,
  output logic       spec_inv,
  output logic [6:0] if_frac,
  output logic       ref_mode,
  output logic [6:0] if_mod,
  output logic [4:0] if_div_hi,
  output logic [2:0] if_div_lo,
  output logic       xo_lowpwr,
  output logic [6:0] rf_frac,
  output logic [4:0] rf_div_hi,
  output logic [2:0] rf_div_lo
);
  logic [3:0]        sync_q;
  logic              pe_s, ld_s, sclk_s, sdat_s;
  logic              ready, commit;
  logic [WORD_W-1:0] word;
  logic [RAW_W-1:0]  raw_all;
  logic [N_REGS-1:0] hit;

  ctl_sbank_sync #(.N_SIG(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({pwr_en, ser_ld, ser_clk, ser_dat}),
    .q(sync_q)
  );
  assign {pe_s, ld_s, sclk_s, sdat_s} = sync_q;

  ctl_sbank_frame #(.WAKE_CYCLES(WAKE_CYCLES)) u_frame (
    .clk(clk), .rst_n(rst_n), .pe_s(pe_s), .ld_s(ld_s),
    .sclk_s(sclk_s), .sdat_s(sdat_s),
    .ready(ready), .commit(commit), .word(word)
  );

  ctl_sbank_regs u_regs (
    .clk(clk), .rst_n(rst_n), .pe_s(pe_s), .commit(commit),
    .word(word), .raw(raw_all), .hit(hit)
  );

  // field decode, register index n at raw_all[n*8 +: 8]
  assign gain_pin_sel = raw_all[7];
  assign tx_hilin     = raw_all[6];
  assign ref_sel      = raw_all[5];
  assign frac_if_en   = raw_all[4];
  assign band_a       = raw_all[2];
  assign pwr_state    = raw_all[1:0];
  assign cp_cont      = raw_all[15];
  assign tx_gain      = raw_all[14:10];
  assign ref_prediv   = raw_all[23];
  assign rf_mod       = raw_all[22:16];
  assign spec_inv     = raw_all[31];
  assign if_frac      = raw_all[30:24];
  assign ref_mode     = raw_all[39];
  assign if_mod       = raw_all[38:32];
  assign if_div_hi    = raw_all[47:43];
  assign if_div_lo    = raw_all[42:40];
  assign xo_lowpwr    = raw_all[55];
  assign rf_frac      = raw_all[54:48];
  assign rf_div_hi    = raw_all[63:59];
  assign rf_div_lo    = raw_all[58:56];
endmodule

// File: rtl/ctl_sbank_chk.sv
`timescale 1ns/1ps
module ctl_sbank_chk
  import ctl_sbank_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              pe_s,
  input logic              ld_s,
  input logic              commit,
  input logic [RAW_W-1:0]  raw_all,
  input logic [N_REGS-1:0] hit
);
  // R6: contents only move on a commit or while asleep
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pe_s && !commit) |=> $stable(raw_all));

  // R7: sleep forces the default image
  p_sleep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !pe_s |=> (raw_all == dflt_all()));

  // R1: defaults present when power enable rises
  p_rise_dflt_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pe_s) |-> (raw_all == dflt_all()));

  // R2: a commit follows a synchronized strobe rise
  p_commit_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> ($past(ld_s) && !$past(ld_s, 2)));

  // R8: no commit right after wake-up
  p_wake_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pe_s) |=> !commit);

  // R3: one register at most takes a word
  p_hit_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit));
endmodule

bind ctl_sbank ctl_sbank_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pe_s(pe_s), .ld_s(ld_s),
  .commit(commit), .raw_all(raw_all), .hit(hit)
);

// File: tb/sim_ctl_sbank.sv
`timescale 1ns/1ps
module sim_ctl_sbank;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_en = 1'b0, ser_clk = 1'b0, ser_dat = 1'b0, ser_ld = 1'b1;
  logic [1:0] pwr_state; logic band_a, gain_pin_sel, tx_hilin, ref_sel, frac_if_en, cp_cont;
  logic [4:0] tx_gain; logic ref_prediv; logic [6:0] rf_mod; logic spec_inv; logic [6:0] if_frac;
  logic ref_mode; logic [6:0] if_mod; logic [4:0] if_div_hi; logic [2:0] if_div_lo;
  logic xo_lowpwr; logic [6:0] rf_frac; logic [4:0] rf_div_hi; logic [2:0] rf_div_lo;

  int total = 0, fails = 0, cyc = 0;
  bit done = 0;
  logic [7:0] mdl [8];

  always #4 clk = ~clk;

  ctl_sbank u0 (.*);

  logic [60:0] obs;
  assign obs = {gain_pin_sel, tx_hilin, ref_sel, frac_if_en, band_a, pwr_state, cp_cont, tx_gain,
                ref_prediv, rf_mod, spec_inv, if_frac, ref_mode, if_mod, if_div_hi, if_div_lo,
                xo_lowpwr, rf_frac, rf_div_hi, rf_div_lo};

  // {commit expected, word}: R2 R3 (known patterns), R4 (unknown patterns)
  localparam logic [16:0] VEC [12] = '{
    {1'b1, 16'h57DA}, {1'b1, 16'hA6DF}, {1'b1, 16'h3ADD}, {1'b1, 16'hC5D8},
    {1'b1, 16'hFFD9}, {1'b1, 16'h9BDB}, {1'b1, 16'h21DC}, {1'b1, 16'h7EDE},
    {1'b0, 16'h00D7}, {1'b0, 16'h55FF}, {1'b1, 16'h03DA}, {1'b0, 16'hAA5A}};

  function automatic int pat_idx(input logic [7:0] p);
    case (p)
      8'hDA: return 0; 8'hDF: return 1; 8'hDD: return 2; 8'hD8: return 3;
      8'hD9: return 4; 8'hDB: return 5; 8'hDC: return 6; 8'hDE: return 7;
      default: return -1;
    endcase
  endfunction

  function automatic logic [60:0] exp_vec();
    return {mdl[0][7], mdl[0][6], mdl[0][5], mdl[0][4], mdl[0][2], mdl[0][1:0],
            mdl[1][7], mdl[1][6:2], mdl[2], mdl[3], mdl[4], mdl[5], mdl[6], mdl[7]};
  endfunction

  task automatic mdl_dflt();
    for (int i = 0; i < 8; i++) mdl[i] = 8'h00;
    mdl[0][7] = 1'b1;                       // gain from pins
    mdl[2] = {1'b1, 7'd79};                 // prescaler, modulus
    mdl[3][7] = 1'b1;                       // spectral inversion
    mdl[6] = {1'b1, 7'd48};                 // xo low power, fraction
    mdl[7] = {5'd10, 3'd0};                 // divider fields
  endtask

  task automatic chk(input string req, input logic [60:0] act, input logic [60:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_dflt_vals(input string req);
    total++;
    if (!(pwr_state == 2'd0 && band_a == 1'b0 && gain_pin_sel && !frac_if_en && xo_lowpwr &&
          ref_prediv && spec_inv && rf_div_hi == 5'd10 && rf_div_lo == 3'd0 &&
          rf_frac == 7'd48 && rf_mod == 7'd79)) begin
      fails++;
      $display("FAIL %s: got %h expected default field values", req, obs);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ld_begin(); ser_ld = 1'b0; wait_cyc(4); endtask
  task automatic ld_end();   wait_cyc(4); ser_ld = 1'b1; wait_cyc(12); endtask
  task automatic put_bit(input logic b);
    ser_dat = b; wait_cyc(4); ser_clk = 1'b1; wait_cyc(4); ser_clk = 1'b0;
  endtask

  task automatic xfer(input logic [31:0] w, input int n);
    ld_begin();
    for (int i = n - 1; i >= 0; i--) put_bit(w[i]);
    ld_end();
  endtask

  task automatic apply(input logic [15:0] w);
    int k;
    k = pat_idx(w[7:0]);
    if (k >= 0) mdl[k] = w[15:8];
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      fails++; total++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    mdl_dflt();
    wait_cyc(3);
    chk("R1 reset", obs, exp_vec());
    chk_dflt_vals("R1 reset values");
    rst_n = 1'b1;
    wait_cyc(4);
    // R7: write while asleep has no effect
    xfer({16'h0, 16'hFFDE}, 16);
    chk("R7 sleep write", obs, exp_vec());
    // R8: transfer overlapping wake-up window is lost
    pwr_en = 1'b1;
    xfer({16'h0, 16'h57DA}, 16);
    chk("R8 wake window", obs, exp_vec());
    wait_cyc(100);
    // table walk: R2 R3 R4
    for (int i = 0; i < 12; i++) begin
      xfer({16'h0, VEC[i][15:0]}, 16);
      if (VEC[i][16]) apply(VEC[i][15:0]);
      chk(VEC[i][16] ? "R3 write" : "R4 unknown pattern", obs, exp_vec());
    end
    // R5: short and long transfers
    xfer({16'h0, 16'h11DE}, 15);
    chk("R5 short", obs, exp_vec());
    xfer({15'h0, 1'b1, 16'h11DE}, 17);
    chk("R5 long", obs, exp_vec());
    // R10: clocks while strobe high are ignored
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
    wait_cyc(8);
    xfer({16'h0, 16'hE2DE}, 16);
    apply(16'hE2DE);
    chk("R10 idle clocks", obs, exp_vec());
    // R6: no change mid transfer
    ld_begin();
    for (int i = 15; i >= 8; i--) put_bit(logic'(16'h4ADB >> i));
    chk("R6 half word", obs, exp_vec());
    for (int i = 7; i >= 0; i--) put_bit(logic'(16'h4ADB >> i));
    wait_cyc(12);
    chk("R6 before strobe", obs, exp_vec());
    ld_end();
    apply(16'h4ADB);
    chk("R6 after strobe", obs, exp_vec());
    // R7 / R9: sleep and wake restore defaults
    pwr_en = 1'b0;
    wait_cyc(6);
    mdl_dflt();
    chk("R7 sleep defaults", obs, exp_vec());
    pwr_en = 1'b1;
    wait_cyc(100);
    chk("R9 wake defaults", obs, exp_vec());
    chk_dflt_vals("R1 power enable rise");
    xfer({16'h0, 16'h03DA}, 16);
    apply(16'h03DA);
    chk("R2 after wake", obs, exp_vec());
    // R1: asynchronous reset restores defaults
    rst_n = 1'b0;
    wait_cyc(2);
    mdl_dflt();
    chk("R1 async reset", obs, exp_vec());
    rst_n = 1'b1;
    wait_cyc(4);
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule